// File: doc/BRIEF.md
# Inter-Processor Word FIFO Mailbox

This block links two processors, called side A and side B, through a pair of word queues that run in opposite directions. Each queue holds 16 words of 32 bits. A word that one side writes into its send port is stored in the queue that side owns. The peer reads it back through its receive port, and words leave in the order they were written. A side never sees its own words.

Each side has a 16-bit control word. When read, it shows four status flags: whether the local send queue is empty or full, and whether the local receive queue is empty or full. It also holds a master enable, two interrupt enables and a sticky error flag. A write to the control word can flush the local send queue, which is also the peer's receive queue. It can also acknowledge the error flag.

A read of the receive port is a one-cycle strobe. The popped word appears on the receive data output in the next cycle and stays there until the next successful pop. Each side drives two level interrupts: one while its send queue is empty, and one while its receive queue holds data. Each interrupt is gated by its own enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both control words read 0x0101 (send and receive queues empty, all enables and the error flag 0). Both receive data outputs read 0 and all four interrupts are low.
- R2: Words written to a side's send port while that side is enabled come out of the peer's receive port in write order. A receive strobe in cycle n, with the queue non-empty and the reader enabled, shows the popped word on the receive data output from cycle n+1. The output holds that word until the next pop.
- R3: Control bit 0 is 1 when the local send queue is empty, and bit 1 is 1 when it holds 16 words. Bit 8 is 1 when the local receive queue is empty, and bit 9 is 1 when it holds 16 words. Bit 3 always reads 0.
- R4: A send write to a full queue while enabled is discarded and sets the error flag (control bit 14) in the next cycle.
- R5: A receive strobe on an empty queue while enabled pops nothing. The receive output keeps the most recently popped word, and the error flag is set.
- R6: Writing the control word with bit 14 = 1 clears the error flag. A write with bit 14 = 0 leaves it set. If a new error occurs in the same cycle as the clear, the flag stays set.
- R7: Writing the control word with bit 3 = 1 empties the local send queue. In the next cycle the local bit 0 and the peer's bit 8 read 1. The peer's receive data output is left unchanged.
- R8: While a side's enable (control bit 15) is 0, its send writes are dropped and its receive strobes pop nothing. Neither case sets the error flag.
- R9: A side's send-empty interrupt equals control bit 2 AND the local send queue being empty.
- R10: A side's receive interrupt equals control bit 10 AND the local receive queue being non-empty.
- R11: The two queues are independent. Traffic in one direction neither reorders nor corrupts the other, including when both sides write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ctrl_we_i | input | 1 | Side A control write strobe |
| a_ctrl_wdata_i | input | 16 | Side A control write data |
| a_ctrl_o | output | 16 | Side A control/status read value |
| a_send_we_i | input | 1 | Side A send write strobe |
| a_send_data_i | input | 32 | Side A word to send |
| a_recv_re_i | input | 1 | Side A receive read strobe |
| a_recv_data_o | output | 32 | Side A last received word |
| a_irq_tx_empty_o | output | 1 | Side A send-empty interrupt |
| a_irq_rx_avail_o | output | 1 | Side A receive-not-empty interrupt |
| b_ctrl_we_i | input | 1 | Side B control write strobe |
| b_ctrl_wdata_i | input | 16 | Side B control write data |
| b_ctrl_o | output | 16 | Side B control/status read value |
| b_send_we_i | input | 1 | Side B send write strobe |
| b_send_data_i | input | 32 | Side B word to send |
| b_recv_re_i | input | 1 | Side B receive read strobe |
| b_recv_data_o | output | 32 | Side B last received word |
| b_irq_tx_empty_o | output | 1 | Side B send-empty interrupt |
| b_irq_rx_avail_o | output | 1 | Side B receive-not-empty interrupt |

## Verification
The properties take for granted that every strobe is a single-cycle level sampled at the clock edge. They also assume that a control write carrying bit 3 or bit 14 is a deliberate action, so its effect is expected one cycle later. The random stimulus changes inputs only on the falling edge and keeps the enable bit mostly set, so overflow, underflow and flush occur often while enabled. It also sometimes clears the enable, which covers the dropped-access paths. Fill and drain phases alternate so that both queues regularly reach 16 words and zero.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned CTRL_W = 16;

  localparam int unsigned BIT_TX_EMPTY  = 0;
  localparam int unsigned BIT_TX_FULL   = 1;
  localparam int unsigned BIT_TX_IRQ_EN = 2;
  localparam int unsigned BIT_TX_FLUSH  = 3;
  localparam int unsigned BIT_RX_EMPTY  = 8;
  localparam int unsigned BIT_RX_FULL   = 9;
  localparam int unsigned BIT_RX_IRQ_EN = 10;
  localparam int unsigned BIT_ERR       = 14;
  localparam int unsigned BIT_ENABLE    = 15;

  typedef struct packed {
    logic enable;
    logic tx_irq_en;
    logic rx_irq_en;
    logic err;
  } side_state_t;
endpackage

// File: rtl/ipc_word_fifo.sv
module ipc_word_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [DATA_W-1:0] last_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] last_q;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  // flush dominates both ports
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign last_o  = last_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '0;
    else if (do_pop) last_q <= mem_q[rd_ptr_q];
  end
endmodule

// File: rtl/ipc_side_ctrl.sv
module ipc_side_ctrl
  import ipc_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              send_we_i,
  input  logic              recv_re_i,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  output logic              push_o,
  output logic              pop_o,
  output logic              flush_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_tx_empty_o,
  output logic              irq_rx_avail_o
);
  side_state_t st_q;
  logic        err_set;
  logic        unused_wdata;

  assign unused_wdata = ^{ctrl_wdata_i[13:11], ctrl_wdata_i[7:4], ctrl_wdata_i[1:0], ctrl_wdata_i[8], ctrl_wdata_i[9]};

  assign push_o  = send_we_i & st_q.enable & ~tx_full_i;
  assign pop_o   = recv_re_i & st_q.enable & ~rx_empty_i;
  assign flush_o = ctrl_we_i & ctrl_wdata_i[BIT_TX_FLUSH];
  assign err_set = st_q.enable & ((send_we_i & tx_full_i) | (recv_re_i & rx_empty_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        st_q.enable    <= ctrl_wdata_i[BIT_ENABLE];
        st_q.tx_irq_en <= ctrl_wdata_i[BIT_TX_IRQ_EN];
        st_q.rx_irq_en <= ctrl_wdata_i[BIT_RX_IRQ_EN];
      end
      // a fresh error outranks an acknowledge in the same cycle
      if (err_set)                                   st_q.err <= 1'b1;
      else if (ctrl_we_i && ctrl_wdata_i[BIT_ERR])   st_q.err <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o                = '0;
    ctrl_o[BIT_TX_EMPTY]  = tx_empty_i;
    ctrl_o[BIT_TX_FULL]   = tx_full_i;
    ctrl_o[BIT_TX_IRQ_EN] = st_q.tx_irq_en;
    ctrl_o[BIT_RX_EMPTY]  = rx_empty_i;
    ctrl_o[BIT_RX_FULL]   = rx_full_i;
    ctrl_o[BIT_RX_IRQ_EN] = st_q.rx_irq_en;
    ctrl_o[BIT_ERR]       = st_q.err;
    ctrl_o[BIT_ENABLE]    = st_q.enable;
  end

  assign irq_tx_empty_o = st_q.tx_irq_en & tx_empty_i;
  assign irq_rx_avail_o = st_q.rx_irq_en & ~rx_empty_i;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_ctrl_we_i,
  input  logic [CTRL_W-1:0] a_ctrl_wdata_i,
  output logic [CTRL_W-1:0] a_ctrl_o,
  input  logic              a_send_we_i,
  input  logic [DATA_W-1:0] a_send_data_i,
  input  logic              a_recv_re_i,
  output logic [DATA_W-1:0] a_recv_data_o,
  output logic              a_irq_tx_empty_o,
  output logic              a_irq_rx_avail_o,
  input  logic              b_ctrl_we_i,
  input  logic [CTRL_W-1:0] b_ctrl_wdata_i,
  output logic [CTRL_W-1:0] b_ctrl_o,
  input  logic              b_send_we_i,
  input  logic [DATA_W-1:0] b_send_data_i,
  input  logic              b_recv_re_i,
  output logic [DATA_W-1:0] b_recv_data_o,
  output logic              b_irq_tx_empty_o,
  output logic              b_irq_rx_avail_o
);
  localparam int unsigned NSIDE = 2;

  // index 0 = side A, 1 = side B; queue d is written by side d
  logic [NSIDE-1:0] ctrl_we, send_we, recv_re;
  logic [NSIDE-1:0] push, pop, flush, q_empty, q_full, irq_tx, irq_rx;
  logic [CTRL_W-1:0] ctrl_wd [NSIDE];
  logic [CTRL_W-1:0] ctrl_rd [NSIDE];
  logic [DATA_W-1:0] send_d  [NSIDE];
  logic [DATA_W-1:0] q_last  [NSIDE];

  assign ctrl_we    = {b_ctrl_we_i, a_ctrl_we_i};
  assign send_we    = {b_send_we_i, a_send_we_i};
  assign recv_re    = {b_recv_re_i, a_recv_re_i};
  assign ctrl_wd[0] = a_ctrl_wdata_i;
  assign ctrl_wd[1] = b_ctrl_wdata_i;
  assign send_d[0]  = a_send_data_i;
  assign send_d[1]  = b_send_data_i;

  for (genvar d = 0; d < NSIDE; d++) begin : g_queue
    ipc_word_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[d]),
      .data_i  (send_d[d]),
      .pop_i   (pop[NSIDE-1-d]),
      .flush_i (flush[d]),
      .empty_o (q_empty[d]),
      .full_o  (q_full[d]),
      .last_o  (q_last[d])
    );
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    ipc_side_ctrl i_ctrl (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .ctrl_we_i      (ctrl_we[s]),
      .ctrl_wdata_i   (ctrl_wd[s]),
      .send_we_i      (send_we[s]),
      .recv_re_i      (recv_re[s]),
      .tx_empty_i     (q_empty[s]),
      .tx_full_i      (q_full[s]),
      .rx_empty_i     (q_empty[NSIDE-1-s]),
      .rx_full_i      (q_full[NSIDE-1-s]),
      .push_o         (push[s]),
      .pop_o          (pop[s]),
      .flush_o        (flush[s]),
      .ctrl_o         (ctrl_rd[s]),
      .irq_tx_empty_o (irq_tx[s]),
      .irq_rx_avail_o (irq_rx[s])
    );
  end

  assign a_ctrl_o         = ctrl_rd[0];
  assign b_ctrl_o         = ctrl_rd[1];
  assign a_recv_data_o    = q_last[1];
  assign b_recv_data_o    = q_last[0];
  assign a_irq_tx_empty_o = irq_tx[0];
  assign b_irq_tx_empty_o = irq_tx[1];
  assign a_irq_rx_avail_o = irq_rx[0];
  assign b_irq_rx_avail_o = irq_rx[1];
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_ctrl_we_i,
  input logic [15:0]       a_ctrl_wdata_i,
  input logic [15:0]       a_ctrl_o,
  input logic              a_send_we_i,
  input logic [DATA_W-1:0] a_recv_data_o,
  input logic              a_irq_tx_empty_o,
  input logic              a_irq_rx_avail_o,
  input logic              b_ctrl_we_i,
  input logic [15:0]       b_ctrl_wdata_i,
  input logic [15:0]       b_ctrl_o,
  input logic              b_send_we_i,
  input logic [DATA_W-1:0] b_recv_data_o,
  input logic              b_irq_tx_empty_o,
  input logic              b_irq_rx_avail_o
);
  // R3
  a_empty_full_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_ctrl_o[0] && a_ctrl_o[1]) && !(b_ctrl_o[8] && b_ctrl_o[9]));

  // R4
  a_ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_send_we_i && a_ctrl_o[15] && a_ctrl_o[1]) |=> a_ctrl_o[14]);

  // R4
  b_ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_send_we_i && b_ctrl_o[15] && b_ctrl_o[1]) |=> b_ctrl_o[14]);

  // R6
  a_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ctrl_o[14] && !(a_ctrl_we_i && a_ctrl_wdata_i[14])) |=> a_ctrl_o[14]);

  // R7
  a_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ctrl_we_i && a_ctrl_wdata_i[3]) |=> (a_ctrl_o[0] && b_ctrl_o[8]));

  // R7
  b_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_ctrl_we_i && b_ctrl_wdata_i[3]) |=> (b_ctrl_o[0] && a_ctrl_o[8]));

  // R8
  a_disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_ctrl_o[15] |=> $stable(a_recv_data_o));

  // R8
  b_disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_ctrl_o[15] |=> $stable(b_recv_data_o));

  // R9
  tx_irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_irq_tx_empty_o == (a_ctrl_o[2] && a_ctrl_o[0])) &&
    (b_irq_tx_empty_o == (b_ctrl_o[2] && b_ctrl_o[0])));

  // R10
  rx_irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_irq_rx_avail_o == (a_ctrl_o[10] && !a_ctrl_o[8])) &&
    (b_irq_rx_avail_o == (b_ctrl_o[10] && !b_ctrl_o[8])));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DATA_W(DATA_W)) i_ipc_mailbox_chk (.*);

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
  localparam int DEPTH = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        ctrl_we [2];
  logic [15:0] ctrl_wd [2];
  logic        send_we [2];
  logic [31:0] send_d  [2];
  logic        recv_re [2];
  logic [15:0] ctrl_q  [2];
  logic [31:0] rdata   [2];
  logic        irq_tx  [2];
  logic        irq_rx  [2];

  ipc_mailbox i_ipc_mailbox (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_ctrl_we_i(ctrl_we[0]), .a_ctrl_wdata_i(ctrl_wd[0]), .a_ctrl_o(ctrl_q[0]),
    .a_send_we_i(send_we[0]), .a_send_data_i(send_d[0]), .a_recv_re_i(recv_re[0]),
    .a_recv_data_o(rdata[0]), .a_irq_tx_empty_o(irq_tx[0]), .a_irq_rx_avail_o(irq_rx[0]),
    .b_ctrl_we_i(ctrl_we[1]), .b_ctrl_wdata_i(ctrl_wd[1]), .b_ctrl_o(ctrl_q[1]),
    .b_send_we_i(send_we[1]), .b_send_data_i(send_d[1]), .b_recv_re_i(recv_re[1]),
    .b_recv_data_o(rdata[1]), .b_irq_tx_empty_o(irq_tx[1]), .b_irq_rx_avail_o(irq_rx[1])
  );

  int checks = 0;
  int errors = 0;

  // reference model: qa written by A, qb written by B
  logic [31:0] qa[$];
  logic [31:0] qb[$];
  logic        m_en[2], m_txie[2], m_rxie[2], m_err[2];
  logic [31:0] m_last[2];

  function automatic int qsize(int d);
    return (d == 0) ? qa.size() : qb.size();
  endfunction

  function automatic logic [15:0] exp_ctrl(int s);
    logic [15:0] v = '0;
    v[0]  = (qsize(s) == 0);
    v[1]  = (qsize(s) == DEPTH);
    v[2]  = m_txie[s];
    v[8]  = (qsize(1 - s) == 0);
    v[9]  = (qsize(1 - s) == DEPTH);
    v[10] = m_rxie[s];
    v[14] = m_err[s];
    v[15] = m_en[s];
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    qa.delete(); qb.delete();
    for (int s = 0; s < 2; s++) begin
      m_en[s] = 0; m_txie[s] = 0; m_rxie[s] = 0; m_err[s] = 0; m_last[s] = '0;
    end
  endtask

  task automatic model_edge();
    logic push[2], pop[2], flush[2], eset[2];
    for (int s = 0; s < 2; s++) begin
      push[s]  = send_we[s] && m_en[s] && (qsize(s) != DEPTH);
      pop[s]   = recv_re[s] && m_en[s] && (qsize(1 - s) != 0);
      flush[s] = ctrl_we[s] && ctrl_wd[s][3];
      eset[s]  = m_en[s] && ((send_we[s] && qsize(s) == DEPTH) || (recv_re[s] && qsize(1 - s) == 0));
    end
    // queue A->B
    if (flush[0]) qa.delete();
    else begin
      if (pop[1]) m_last[1] = qa.pop_front();
      if (push[0]) qa.push_back(send_d[0]);
    end
    // queue B->A
    if (flush[1]) qb.delete();
    else begin
      if (pop[0]) m_last[0] = qb.pop_front();
      if (push[1]) qb.push_back(send_d[1]);
    end
    for (int s = 0; s < 2; s++) begin
      if (eset[s]) m_err[s] = 1;
      else if (ctrl_we[s] && ctrl_wd[s][14]) m_err[s] = 0;
      if (ctrl_we[s]) begin
        m_en[s]   = ctrl_wd[s][15];
        m_txie[s] = ctrl_wd[s][2];
        m_rxie[s] = ctrl_wd[s][10];
      end
    end
  endtask

  task automatic idle_inputs();
    for (int s = 0; s < 2; s++) begin
      ctrl_we[s] = 0; ctrl_wd[s] = '0; send_we[s] = 0; send_d[s] = '0; recv_re[s] = 0;
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < 2; s++) begin
      check(ctrl_q[s] == exp_ctrl(s), "R3 control word", 32'(ctrl_q[s]), 32'(exp_ctrl(s)));
      check(rdata[s] == m_last[s], "R2 receive data", rdata[s], m_last[s]);
      check(irq_tx[s] == (m_txie[s] && qsize(s) == 0), "R9 send-empty irq",
            32'(irq_tx[s]), 32'(m_txie[s] && qsize(s) == 0));
      check(irq_rx[s] == (m_rxie[s] && qsize(1 - s) != 0), "R10 receive irq",
            32'(irq_rx[s]), 32'(m_rxie[s] && qsize(1 - s) != 0));
    end
  endtask

  // inputs are set at a falling edge; step applies them for one rising edge
  task automatic step();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare_all();
    idle_inputs();
  endtask

  task automatic wr_ctrl(int s, logic [15:0] v);
    ctrl_we[s] = 1; ctrl_wd[s] = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int s = 0; s < 2; s++) begin
      check(ctrl_q[s] == 16'h0101, "R1 control reset", 32'(ctrl_q[s]), 32'h0101);
      check(rdata[s] == '0, "R1 data reset", rdata[s], '0);
      check(!irq_tx[s] && !irq_rx[s], "R1 irq reset", 32'({irq_tx[s], irq_rx[s]}), 0);
    end

    wr_ctrl(0, 16'h8404); wr_ctrl(1, 16'h8404); step();
    check(irq_tx[0] == 1, "R9 empty irq on", 32'(irq_tx[0]), 1);

    for (int i = 0; i < DEPTH; i++) begin
      send_we[0] = 1; send_d[0] = 32'h100 + i; step();
    end
    check(ctrl_q[0][1] == 1, "R3 send full bit", 32'(ctrl_q[0][1]), 1);
    check(ctrl_q[1][9] == 1, "R3 receive full bit", 32'(ctrl_q[1][9]), 1);
    check(irq_rx[1] == 1, "R10 receive irq on", 32'(irq_rx[1]), 1);
    send_we[0] = 1; send_d[0] = 32'hDEAD_BEEF; step();
    check(ctrl_q[0][14] == 1, "R4 overflow error", 32'(ctrl_q[0][14]), 1);

    wr_ctrl(0, 16'h8404); step();
    check(ctrl_q[0][14] == 1, "R6 error kept on 0 write", 32'(ctrl_q[0][14]), 1);
    wr_ctrl(0, 16'hC404); step();
    check(ctrl_q[0][14] == 0, "R6 error cleared", 32'(ctrl_q[0][14]), 0);

    for (int i = 0; i < DEPTH; i++) begin
      recv_re[1] = 1; step();
      check(rdata[1] == 32'h100 + i, "R2 order", rdata[1], 32'h100 + i);
    end
    recv_re[1] = 1; step();
    check(rdata[1] == 32'h10F, "R5 underflow keeps last", rdata[1], 32'h10F);
    check(ctrl_q[1][14] == 1, "R5 underflow error", 32'(ctrl_q[1][14]), 1);
    // set in same cycle as clear: set wins
    recv_re[1] = 1; wr_ctrl(1, 16'hC404); step();
    check(ctrl_q[1][14] == 1, "R6 set beats clear", 32'(ctrl_q[1][14]), 1);
    wr_ctrl(1, 16'hC404); step();

    for (int i = 0; i < 3; i++) begin
      send_we[0] = 1; send_d[0] = 32'h200 + i; step();
    end
    wr_ctrl(0, 16'h840C); step();
    check(ctrl_q[0][0] == 1 && ctrl_q[1][8] == 1, "R7 flush empties",
          32'({ctrl_q[0][0], ctrl_q[1][8]}), 3);
    check(rdata[1] == 32'h10F, "R7 peer data kept", rdata[1], 32'h10F);
    check(ctrl_q[0][3] == 0, "R3 flush bit reads 0", 32'(ctrl_q[0][3]), 0);

    wr_ctrl(1, 16'h0000); step();
    send_we[1] = 1; send_d[1] = 32'h55; step();
    check(ctrl_q[0][8] == 1, "R8 disabled send dropped", 32'(ctrl_q[0][8]), 1);
    check(ctrl_q[1][14] == 0, "R8 no error", 32'(ctrl_q[1][14]), 0);
    send_we[0] = 1; send_d[0] = 32'hAA; step();
    recv_re[1] = 1; step();
    check(rdata[1] == 32'h10F && ctrl_q[1][8] == 0, "R8 disabled read no pop", rdata[1], 32'h10F);
    recv_re[1] = 1; step();
    check(ctrl_q[1][14] == 0, "R8 no error on read", 32'(ctrl_q[1][14]), 0);
    wr_ctrl(1, 16'h8404); step();
    recv_re[1] = 1; step();
    check(rdata[1] == 32'hAA, "R8 re-enabled pop", rdata[1], 32'hAA);

    send_we[0] = 1; send_d[0] = 32'h11; send_we[1] = 1; send_d[1] = 32'h22; step();
    recv_re[0] = 1; recv_re[1] = 1; step();
    check(rdata[0] == 32'h22, "R11 B to A", rdata[0], 32'h22);
    check(rdata[1] == 32'h11, "R11 A to B", rdata[1], 32'h11);

    // random traffic with alternating fill and drain bias
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit fill = ((cyc / 300) % 2) == 0;
      for (int s = 0; s < 2; s++) begin
        send_we[s] = fill ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
        send_d[s]  = $urandom;
        recv_re[s] = fill ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
        if (($urandom % 40) == 0) begin
          logic [15:0] v = 16'($urandom);
          v[15] = (($urandom % 8) != 0);
          v[3]  = (($urandom % 4) == 0);
          wr_ctrl(s, v);
        end
      end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule